// File: doc/BRIEF.md
# Word-Addressed Serial Port with Transmit and Receive Queues

This block is a byte-wide asynchronous serial port. Software reaches it through a small bus that addresses 32-bit words. The bus has a read strobe, a write strobe, a 3-bit word index, 32 bits of write data and 32 bits of read data. Each side of the port has its own eight-entry queue. Bytes that software writes wait in the transmit queue until the transmitter is switched on. They then leave on one output line, one frame at a time. A frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. The receiver watches one input line for the same frame shape. It keeps each good byte in the receive queue until software reads it.

The bit period is set by a divisor register and lasts (divisor + 1) clock cycles. Each queue has a 3-bit level threshold. A pending bit follows each queue's fill level against that threshold. Each pending bit is masked by its own enable bit, and the two masked results drive a single interrupt line. Software can poll the receive pending bit instead of taking the interrupt. With the threshold at zero, that bit simply means that a byte is waiting.

The word index on `addr` is the byte offset divided by four:

| Index | Offset | Register |
|-------|--------|----------|
| 0 | 0x00 | transmit data |
| 1 | 0x04 | receive data |
| 2 | 0x08 | transmit control |
| 3 | 0x0C | receive control |
| 4 | 0x10 | interrupt enable |
| 5 | 0x14 | interrupt pending |
| 6 | 0x18 | baud divisor |

Top module: `mmio_uart`

## Requirements
- R1: After reset the following values hold:
  - Both control words (index 2 and 3) read 0, and the interrupt-enable word (index 4) reads 0.
  - The pending word (index 5) reads 0.
  - The divisor (index 6) reads the parameter DIV_RESET, which is 4 by default.
  - The receive-data word reads 0x8000_0000 and the transmit-data word reads 0.
  - `txd` is high and `irq` is low.
- R2: Writing index 0 pushes `wdata[7:0]` into an 8-entry transmit queue. Reading index 0 returns bit 31 set only while that queue holds 8 bytes. A write to a full queue is dropped. Queued bytes leave in the order they were written.
- R3: The transmitter starts a frame only while bit 0 of the transmit control word is 1. Until then `txd` stays high.
  - A frame is one low start bit, data bits 0 through 7, and one high stop bit.
  - Each bit lasts exactly (div + 1) clock cycles, where div is bits DIV_W-1:0 of index 6. Div = 0 gives one clock per bit.
- R4: Reading index 1 returns the queue state and data in one word.
  - If the receive queue is empty, it returns 0x8000_0000 and removes nothing.
  - Otherwise it returns the oldest byte in bits 7:0 with bit 31 clear, and removes that byte.
- R5: The receiver starts on a falling edge of `rxd`. It accepts the start bit only if the line is still low half a bit period later. It samples each data bit, least significant first, at mid-period. A frame whose stop bit samples low is discarded. A low pulse shorter than half a bit stores nothing.
- R6: Frames that arrive while bit 0 of the receive control word is 0 are not stored.
- R7: The receive queue holds 8 bytes. A byte that completes while the queue is full is dropped, and the 8 stored bytes read back in arrival order.
- R8: Bits 18:16 of each control word hold a 3-bit threshold, and the control words read back as written. Pending bit 0 of index 5 is 1 while the transmit count is below its threshold. Pending bit 1 is 1 while the receive count is above its threshold.
- R9: `irq` is high exactly when some pending bit and its matching bit 1:0 of index 4 are both 1. Writes to index 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and for bit timing |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read strobe. A receive-data read removes a byte at the closing edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, valid in the same cycle |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line, high when idle |
| irq | output | 1 | Masked pending indication |

## Verification
Read data is combinational, so the bench samples `rdata` 1 ns after the falling edge of the strobe cycle. Register writes take effect at the next rising edge, and `irq` and the pending word are checked at the falling edge after it.

A transmit byte becomes visible two edges after its write: one edge to enter the queue, one to load the shifter. The bench therefore polls `txd` at each falling edge until the start bit appears. From there it compares all 10·(div+1) samples against the expected frame, so a period off by one cycle is caught.

A received byte becomes readable at the rising edge after the stop-bit midpoint, as seen through the two-stage synchronizer. The bench leaves four idle clocks after each stop bit before any read.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;

  localparam int REG_IDX_W  = 3;
  localparam int DATA_W     = 8;
  localparam int BUS_W      = 32;
  localparam int FLAG_BIT   = 31;
  localparam int WM_LSB     = 16;
  localparam int WM_W       = 3;
  localparam int FRAME_BITS = DATA_W + 2;

  typedef enum logic [REG_IDX_W-1:0] {
    A_TXDATA = 3'd0,
    A_RXDATA = 3'd1,
    A_TXCTRL = 3'd2,
    A_RXCTRL = 3'd3,
    A_IE     = 3'd4,
    A_IP     = 3'd5,
    A_DIV    = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign dout    = mem[rp_q];
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = wp_q + 1'b1;
    if (do_pop)  rp_d = rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; written only when a push is accepted
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import mmio_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic              txd,
  output logic              busy
);

  localparam int BIT_CW = $clog2(FRAME_BITS);

  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [BIT_CW-1:0]     bit_q, bit_d;
  logic [DIV_W-1:0]      cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    q_pop  = 1'b0;
    if (!busy_q) begin
      if (en && !q_empty) begin
        q_pop  = 1'b1;
        busy_d = 1'b1;
        sh_d   = {1'b1, q_data, 1'b0};
        bit_d  = '0;
        cnt_d  = div;
      end
    end else if (cnt_q == '0) begin
      cnt_d = div;
      if (bit_q == BIT_CW'(FRAME_BITS - 1)) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
        bit_d = bit_q + 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import mmio_uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              rxd,
  output logic              push,
  output logic [DATA_W-1:0] data,
  output logic              line
);

  rx_state_e         st_q, st_d;
  logic              s1_q, s2_q, prev_q;
  logic [DIV_W-1:0]  cnt_q, cnt_d, half;
  logic [2:0]        bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  assign half = div >> 1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    push  = 1'b0;
    if (!en) begin
      st_d = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (prev_q && !s2_q) begin
            bit_d = '0;
            if (half == '0) begin
              st_d  = RX_DATA;
              cnt_d = div;
            end else begin
              st_d  = RX_START;
              cnt_d = half - 1'b1;
            end
          end
        end
        RX_START: begin
          if (cnt_q == '0) begin
            st_d  = s2_q ? RX_IDLE : RX_DATA;
            cnt_d = div;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == '0) begin
            sh_d  = {s2_q, sh_q[DATA_W-1:1]};
            cnt_d = div;
            bit_d = bit_q + 1'b1;
            if (bit_q == 3'd7) st_d = RX_STOP;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          if (cnt_q == '0) begin
            st_d = RX_IDLE;
            push = s2_q;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end

  assign data = sh_q;
  assign line = s2_q;

endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int DIV_RESET  = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int FIFO_CW   = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] addr,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     rdata,
  input  logic                 rxd,
  output logic                 txd,
  output logic                 irq
);

  // reset: asserted at once, released after two clocks
  logic rs1_q, rs2_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_n_s = rs2_q;

  logic             tx_en_q, tx_en_d, rx_en_q, rx_en_d;
  logic [WM_W-1:0]  tx_wm_q, tx_wm_d, rx_wm_q, rx_wm_d;
  logic [1:0]       ie_q, ie_d;
  logic [DIV_W-1:0] div_q, div_d;

  logic               tx_push, tx_pop, tx_full, tx_empty;
  logic [DATA_W-1:0]  tx_dout;
  logic [FIFO_CW-1:0] tx_cnt;
  logic               rx_push, rx_pop, rx_full, rx_empty;
  logic [DATA_W-1:0]  rx_byte, rx_dout;
  logic [FIFO_CW-1:0] rx_cnt;
  logic               tx_busy, rx_line;
  logic [1:0]         ip;

  assign tx_push = wr_en && (addr == A_TXDATA);
  assign rx_pop  = rd_en && (addr == A_RXDATA);

  always_comb begin
    tx_en_d = tx_en_q;
    rx_en_d = rx_en_q;
    tx_wm_d = tx_wm_q;
    rx_wm_d = rx_wm_q;
    ie_d    = ie_q;
    div_d   = div_q;
    if (wr_en) begin
      case (addr)
        A_TXCTRL: begin
          tx_en_d = wdata[0];
          tx_wm_d = wdata[WM_LSB +: WM_W];
        end
        A_RXCTRL: begin
          rx_en_d = wdata[0];
          rx_wm_d = wdata[WM_LSB +: WM_W];
        end
        A_IE:    ie_d  = wdata[1:0];
        A_DIV:   div_d = wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      tx_wm_q <= '0;
      rx_wm_q <= '0;
      ie_q    <= '0;
      div_q   <= DIV_W'(DIV_RESET);
    end else begin
      tx_en_q <= tx_en_d;
      rx_en_q <= rx_en_d;
      tx_wm_q <= tx_wm_d;
      rx_wm_q <= rx_wm_d;
      ie_q    <= ie_d;
      div_q   <= div_d;
    end
  end

  uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_s), .push(tx_push), .din(wdata[DATA_W-1:0]),
    .pop(tx_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );

  uart_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n_s), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_dout), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .en(tx_en_q), .div(div_q),
    .q_empty(tx_empty), .q_data(tx_dout), .q_pop(tx_pop), .txd(txd), .busy(tx_busy)
  );

  uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .en(rx_en_q), .div(div_q),
    .rxd(rxd), .push(rx_push), .data(rx_byte), .line(rx_line)
  );

  assign ip[0] = tx_cnt < FIFO_CW'(tx_wm_q);
  assign ip[1] = rx_cnt > FIFO_CW'(rx_wm_q);
  assign irq   = |(ip & ie_q);

  always_comb begin
    rdata = '0;
    case (addr)
      A_TXDATA: rdata[FLAG_BIT] = tx_full;
      A_RXDATA: begin
        rdata[FLAG_BIT] = rx_empty;
        if (!rx_empty) rdata[DATA_W-1:0] = rx_dout;
      end
      A_TXCTRL: begin
        rdata[0]                = tx_en_q;
        rdata[WM_LSB +: WM_W]   = tx_wm_q;
      end
      A_RXCTRL: begin
        rdata[0]                = rx_en_q;
        rdata[WM_LSB +: WM_W]   = rx_wm_q;
      end
      A_IE:    rdata[1:0] = ie_q;
      A_IP:    rdata[1:0] = ip;
      A_DIV:   rdata[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  logic unused_sig;
  assign unused_sig = ^{wdata, rx_full, tx_busy, rx_line};

endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk
  import mmio_uart_pkg::*;
(
  input logic                 clk,
  input logic                 rst_ns,
  input logic                 tx_en,
  input logic                 rx_en,
  input logic                 tx_busy,
  input logic                 tx_full,
  input logic                 tx_push,
  input logic                 tx_pop,
  input logic                 rx_push,
  input logic                 rx_line,
  input logic                 rx_empty,
  input logic                 rd_en,
  input logic [REG_IDX_W-1:0] addr,
  input logic [1:0]           ie,
  input logic                 irq
);

  // R3
  tx_start_gated_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(tx_busy) |-> $past(tx_en));

  // R2
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (tx_full && tx_push && !tx_pop) |=> tx_full);

  // R4
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && addr == A_RXDATA && rx_empty && !rx_push) |=> rx_empty);

  // R5
  rx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rx_push |-> rx_line);

  // R6
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rx_push |-> rx_en);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (ie == 2'b00) |-> !irq);

endmodule

bind mmio_uart mmio_uart_chk u_chk (
  .clk(clk), .rst_ns(rst_n_s), .tx_en(tx_en_q), .rx_en(rx_en_q),
  .tx_busy(tx_busy), .tx_full(tx_full), .tx_push(tx_push), .tx_pop(tx_pop),
  .rx_push(rx_push), .rx_line(rx_line), .rx_empty(rx_empty),
  .rd_en(rd_en), .addr(addr), .ie(ie_q), .irq(irq)
);

// File: tb/tb_mmio_uart.sv
module tb_mmio_uart;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rxd = 1'b1;
  logic        txd;
  logic        irq;

  int total = 0;
  int bad   = 0;
  int bdiv  = 4;

  always #4 clk = ~clk;

  mmio_uart dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cap_frame(input logic [7:0] b, input int dv, input string req);
    logic [9:0] fr;
    int waitc;
    int errs;
    fr = {1'b1, b, 1'b0};
    waitc = 0;
    errs = 0;
    while (txd !== 1'b0 && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    if (waitc >= 3000) errs = 999;
    else begin
      for (int i = 0; i < 10 * (dv + 1); i++) begin
        if (txd !== fr[i / (dv + 1)]) errs++;
        @(negedge clk);
      end
    end
    chk(req, errs, 0);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    rxd = 1'b0;
    repeat (bdiv + 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bdiv + 1) @(negedge clk);
    end
    rxd = stop;
    repeat (bdiv + 1) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 txd idle", {31'b0, txd}, 32'd1);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    rd(3'd2, d); chk("R1 txctrl", d, 32'h0);
    rd(3'd3, d); chk("R1 rxctrl", d, 32'h0);
    rd(3'd4, d); chk("R1 ie", d, 32'h0);
    rd(3'd5, d); chk("R1 ip", d, 32'h0);
    rd(3'd6, d); chk("R1 div", d, 32'd4);
    rd(3'd1, d); chk("R1 rxdata empty", d, 32'h8000_0000);
    rd(3'd0, d); chk("R1 txdata", d, 32'h0);
  endtask

  task automatic t_tx_fill();
    logic [31:0] d;
    int lows;
    for (int i = 0; i < 9; i++) wr(3'd0, 32'(8'(i * 37 + 5)));
    rd(3'd0, d); chk("R2 full flag", d, 32'h8000_0000);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R3 idle while disabled", lows, 0);
    wr(3'd2, 32'h1);
    for (int i = 0; i < 8; i++) cap_frame(8'(i * 37 + 5), 4, "R2 R3 queued frame");
    lows = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R2 ninth write dropped", lows, 0);
    rd(3'd0, d); chk("R2 not full after drain", d, 32'h0);
  endtask

  task automatic t_tx_div();
    logic [31:0] d;
    wr(3'd6, 32'h0);
    rd(3'd6, d); chk("R3 div readback", d, 32'h0);
    wr(3'd0, 32'hA5);
    cap_frame(8'hA5, 0, "R3 div0 frame");
    wr(3'd6, 32'h2);
    wr(3'd0, 32'h3C);
    cap_frame(8'h3C, 2, "R3 div2 frame");
    wr(3'd6, 32'h4);
  endtask

  task automatic t_rx_basic();
    logic [31:0] d;
    wr(3'd3, 32'h1);
    send_frame(8'h5A, 1'b1);
    send_frame(8'hC3, 1'b1);
    rd(3'd1, d); chk("R4 first byte", d, 32'h5A);
    rd(3'd1, d); chk("R4 second byte", d, 32'hC3);
    rd(3'd1, d); chk("R4 empty read", d, 32'h8000_0000);
    send_frame(8'h7E, 1'b1);
    rd(3'd1, d); chk("R4 after empty read", d, 32'h7E);
  endtask

  task automatic t_rx_errors();
    logic [31:0] d;
    rxd = 1'b0;
    @(negedge clk);
    rxd = 1'b1;
    repeat (60) @(negedge clk);
    rd(3'd1, d); chk("R5 glitch ignored", d, 32'h8000_0000);
    send_frame(8'h96, 1'b0);
    rd(3'd1, d); chk("R5 bad stop discarded", d, 32'h8000_0000);
    send_frame(8'h01, 1'b1);
    rd(3'd1, d); chk("R5 lsb first", d, 32'h01);
  endtask

  task automatic t_rx_disable();
    logic [31:0] d;
    wr(3'd3, 32'h0);
    send_frame(8'h44, 1'b1);
    wr(3'd3, 32'h1);
    rd(3'd1, d); chk("R6 disabled frame not stored", d, 32'h8000_0000);
  endtask

  task automatic t_rx_overflow();
    logic [31:0] d;
    for (int i = 0; i < 9; i++) send_frame(8'(8'h20 + i), 1'b1);
    for (int i = 0; i < 8; i++) begin
      rd(3'd1, d); chk("R7 stored order", d, 32'(8'h20 + i));
    end
    rd(3'd1, d); chk("R7 ninth dropped", d, 32'h8000_0000);
  endtask

  task automatic t_wm();
    logic [31:0] d;
    wr(3'd2, 32'h0003_0000);
    wr(3'd3, 32'h0001_0001);
    rd(3'd2, d); chk("R8 txctrl readback", d, 32'h0003_0000);
    rd(3'd3, d); chk("R8 rxctrl readback", d, 32'h0001_0001);
    rd(3'd5, d); chk("R8 tx below threshold", d, 32'h1);
    chk("R9 masked", {31'b0, irq}, 32'd0);
    wr(3'd4, 32'h1);
    chk("R9 tx irq", {31'b0, irq}, 32'd1);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R9 pending write ignored", d, 32'h1);
    for (int i = 0; i < 3; i++) wr(3'd0, 32'h11);
    rd(3'd5, d); chk("R8 tx at threshold", d, 32'h0);
    chk("R9 irq clears", {31'b0, irq}, 32'd0);
    send_frame(8'h61, 1'b1);
    rd(3'd5, d); chk("R8 rx at threshold", d, 32'h0);
    send_frame(8'h62, 1'b1);
    rd(3'd5, d); chk("R8 rx above threshold", d, 32'h2);
    chk("R9 rx not enabled", {31'b0, irq}, 32'd0);
    wr(3'd4, 32'h2);
    chk("R9 rx irq", {31'b0, irq}, 32'd1);
    rd(3'd1, d);
    rd(3'd1, d);
    chk("R9 rx irq after drain", {31'b0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tx_fill();
    t_tx_div();
    t_rx_basic();
    t_rx_errors();
    t_rx_disable();
    t_rx_overflow();
    t_wm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule